// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is one bank of general-purpose pins, 32 wide by default, run from a plain memory-mapped register port. The port has an address, a write strobe and write data, and it gives back read data combinationally.

For each pin the bank holds an output level and a drive enable. Software never writes either one directly. It writes a mask to a set offset or a clear offset, so several agents can change disjoint pins without a read-modify-write. Every pin also feeds a two-flop synchroniser. The synchronised value is readable, and it is compared with its own copy from the previous cycle to find rising and falling edges.

Each edge kind has its own per-pin enable mask. An enabled edge latches a pending bit, and software clears pending bits by writing ones. The single interrupt line is high while any pending bit is set. There is no streaming data path, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the output levels, drive enables, both edge enable masks and all pending bits are zero, every pin is an input, and `irq` is low.
- R2: A write to offset 0x14 sets the `pin_out` bits that are one in the write data, from the next cycle on. Bits written as zero keep their value, and `pin_out` changes only on writes to 0x14 or 0x18.
- R3: A write to offset 0x18 clears the `pin_out` bits that are one in the write data, and the other bits keep their value.
- R4: A write to 0x1C sets `pin_oe` bits and a write to 0x20 clears them, one bit per pin, with a one meaning the pin drives. A read at 0x04 returns `pin_oe`.
- R5: A read at 0x00 returns `pin_in` as seen through two synchroniser flops, so a change of the pin is visible two clock edges later.
- R6: With its bit set in the rising mask (offset 0x28), a synchronised 0-to-1 change latches the pin's pending bit. With its bit set in the falling mask (offset 0x2C), a 1-to-0 change does the same. A pin enabled in both masks latches on either change. The pending bit is set on the third clock edge after the pin change.
- R7: An edge on a pin whose mask bit for that edge kind is zero leaves the pending register unchanged.
- R8: A write to 0x0C clears the pending bits written as one, leaves the others, and a read at 0x0C returns the pending register.
- R9: If an enabled edge on a pin is found in the same cycle as a write that clears that pin's pending bit, the bit stays set.
- R10: `irq` is high exactly when at least one pending bit is set.
- R11: Reads of 0x14, 0x18, 0x1C, 0x20 and of any unmapped offset return zero. Writes to 0x00, 0x04 or unmapped offsets change no state.
- R12: The rising and falling masks read back at 0x28 and 0x2C the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | NUM_PINS (32) | Write data, one bit per pin |
| reg_rdata | output | NUM_PINS (32) | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS (32) | Asynchronous pin levels from the pads |
| pin_out | output | NUM_PINS (32) | Output level per pin |
| pin_oe | output | NUM_PINS (32) | Drive enable per pin, one means output |
| irq | output | 1 | Interrupt, high while any pending bit is set |

## Verification
The bound checker examines every cycle for four things:
- the bit arithmetic of the set and clear writes on both the level and the enable vectors;
- that `pin_out` holds between such writes;
- that `irq` cannot drop without a pending-clear write;
- that write-only and unmapped offsets read as zero.

The latency through the synchroniser, the edge-kind masking, and the race between a new edge and an acknowledge in the same cycle all depend on the history of `pin_in`. Only the bench scenarios can show these, by comparing against a cycle model during directed timing cases and a long random run.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register offsets; the software map depends on these values.
  typedef enum logic [7:0] {
    OFS_IN      = 8'h00,
    OFS_OE      = 8'h04,
    OFS_PEND    = 8'h0C,
    OFS_OUT_SET = 8'h14,
    OFS_OUT_CLR = 8'h18,
    OFS_OE_SET  = 8'h1C,
    OFS_OE_CLR  = 8'h20,
    OFS_RISE_EN = 8'h28,
    OFS_FALL_EN = 8'h2C
  } reg_ofs_e;

  // One-cycle write strobes decoded from the register port.
  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic oe_set;
    logic oe_clr;
    logic rise_wr;
    logic fall_wr;
    logic pend_clr;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchroniser followed by a one-cycle edge detector.
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[LAST];
  end

  assign sync_q = stage_q[LAST];
  assign rise   = stage_q[LAST] & ~prev_q;
  assign fall   = ~stage_q[LAST] & prev_q;
endmodule

// File: rtl/gpio_set_clr_reg.sv
// Bit vector changed only through set-mask and clear-mask strobes.
module gpio_set_clr_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_n;

  always_comb begin
    q_n = q;
    if (set_stb) q_n = q_n | mask;
    if (clr_stb) q_n = q_n & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Edge enable masks, sticky pending bits with write-one-to-clear, interrupt.
module gpio_irq_ctrl #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_wr,
  input  logic             fall_wr,
  input  logic             pend_clr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] rise,
  input  logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] rise_en,
  output logic [WIDTH-1:0] fall_en,
  output logic [WIDTH-1:0] pend,
  output logic             irq
);
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] ack_mask;
  logic [WIDTH-1:0] pend_n;

  assign hit      = (rise & rise_en) | (fall & fall_en);
  assign ack_mask = pend_clr ? wdata : '0;
  // A fresh hit outranks the acknowledge of the same bit.
  assign pend_n   = (pend & ~ack_mask) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      pend    <= '0;
    end else begin
      if (rise_wr) rise_en <= wdata;
      if (fall_wr) fall_en <= wdata;
      pend <= pend_n;
    end
  end

  assign irq = |pend;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int unsigned NUM_VEC = 2;  // level vector and drive-enable vector
  localparam int unsigned VEC_OUT = 0;
  localparam int unsigned VEC_OE  = 1;

  function automatic logic at(input logic [ADDR_W-1:0] a, input reg_ofs_e o);
    return a == ADDR_W'(o);
  endfunction

  wr_strobe_t       stb;
  logic [NUM_PINS-1:0] sync_in, rise, fall;
  logic [NUM_PINS-1:0] rise_en, fall_en, pend;
  logic [NUM_PINS-1:0] vec_q   [NUM_VEC];
  logic                vec_set [NUM_VEC];
  logic                vec_clr [NUM_VEC];

  always_comb begin
    stb          = '0;
    stb.out_set  = reg_we && at(reg_addr, OFS_OUT_SET);
    stb.out_clr  = reg_we && at(reg_addr, OFS_OUT_CLR);
    stb.oe_set   = reg_we && at(reg_addr, OFS_OE_SET);
    stb.oe_clr   = reg_we && at(reg_addr, OFS_OE_CLR);
    stb.rise_wr  = reg_we && at(reg_addr, OFS_RISE_EN);
    stb.fall_wr  = reg_we && at(reg_addr, OFS_FALL_EN);
    stb.pend_clr = reg_we && at(reg_addr, OFS_PEND);
  end

  assign vec_set[VEC_OUT] = stb.out_set;
  assign vec_clr[VEC_OUT] = stb.out_clr;
  assign vec_set[VEC_OE]  = stb.oe_set;
  assign vec_clr[VEC_OE]  = stb.oe_clr;

  generate
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      gpio_set_clr_reg #(.WIDTH(NUM_PINS)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (vec_set[v]),
        .clr_stb (vec_clr[v]),
        .mask    (reg_wdata),
        .q       (vec_q[v])
      );
    end
  endgenerate

  assign pin_out = vec_q[VEC_OUT];
  assign pin_oe  = vec_q[VEC_OE];

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_in),
    .sync_q (sync_in),
    .rise   (rise),
    .fall   (fall)
  );

  gpio_irq_ctrl #(.WIDTH(NUM_PINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_wr  (stb.rise_wr),
    .fall_wr  (stb.fall_wr),
    .pend_clr (stb.pend_clr),
    .wdata    (reg_wdata),
    .rise     (rise),
    .fall     (fall),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .pend     (pend),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (at(reg_addr, OFS_IN))      reg_rdata = sync_in;
    if (at(reg_addr, OFS_OE))      reg_rdata = pin_oe;
    if (at(reg_addr, OFS_PEND))    reg_rdata = pend;
    if (at(reg_addr, OFS_RISE_EN)) reg_rdata = rise_en;
    if (at(reg_addr, OFS_FALL_EN)) reg_rdata = fall_en;
  end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_we,
  input logic [NUM_PINS-1:0] reg_wdata,
  input logic [NUM_PINS-1:0] reg_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq
);
  logic w_oset, w_oclr, w_eset, w_eclr, w_pend, rd_zero;
  assign w_oset = reg_we && reg_addr == ADDR_W'(OFS_OUT_SET);
  assign w_oclr = reg_we && reg_addr == ADDR_W'(OFS_OUT_CLR);
  assign w_eset = reg_we && reg_addr == ADDR_W'(OFS_OE_SET);
  assign w_eclr = reg_we && reg_addr == ADDR_W'(OFS_OE_CLR);
  assign w_pend = reg_we && reg_addr == ADDR_W'(OFS_PEND);
  assign rd_zero = !(reg_addr == ADDR_W'(OFS_IN) || reg_addr == ADDR_W'(OFS_OE) ||
                     reg_addr == ADDR_W'(OFS_PEND) || reg_addr == ADDR_W'(OFS_RISE_EN) ||
                     reg_addr == ADDR_W'(OFS_FALL_EN));

  p_out_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_oset |=> pin_out == ($past(pin_out) | $past(reg_wdata)));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_oset || w_oclr) |=> $stable(pin_out));

  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_oclr |=> pin_out == ($past(pin_out) & ~$past(reg_wdata)));

  p_oe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_eset |=> pin_oe == ($past(pin_oe) | $past(reg_wdata)));

  p_oe_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_eclr |=> pin_oe == ($past(pin_oe) & ~$past(reg_wdata)));

  p_oe_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_W'(OFS_OE) |-> reg_rdata == pin_oe);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !w_pend) |=> irq);

  p_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> reg_rdata == '0);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/test_gpio_edge_bank.sv
`timescale 1ns/1ps
module test_gpio_edge_bank;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state, kept from the requirements
  logic [N-1:0] m_out = '0, m_oe = '0, m_ren = '0, m_fen = '0, m_pend = '0;
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prv = '0;

  always #4 clk = ~clk;

  gpio_edge_bank #(.NUM_PINS(N), .ADDR_W(8), .SYNC_STAGES(2)) i_gpio_edge_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  function automatic logic [N-1:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_s2;
      8'h04: return m_oe;
      8'h0C: return m_pend;
      8'h28: return m_ren;
      8'h2C: return m_fen;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00: return "R5";
      8'h04: return "R4";
      8'h0C: return "R8";
      8'h28, 8'h2C: return "R12";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge.
  task automatic cyc(input logic [7:0] a, input logic we, input logic [N-1:0] wd,
                     input logic [N-1:0] pins);
    logic [N-1:0] er, ef;
    reg_addr = a; reg_we = we; reg_wdata = wd; pin_in = pins;
    @(posedge clk);
    er = m_s2 & ~m_prv;
    ef = ~m_s2 & m_prv;
    m_pend = (m_pend & ~((we && a == 8'h0C) ? wd : '0)) | (er & m_ren) | (ef & m_fen);
    if (we) begin
      case (a)
        8'h14: m_out = m_out | wd;
        8'h18: m_out = m_out & ~wd;
        8'h1C: m_oe = m_oe | wd;
        8'h20: m_oe = m_oe & ~wd;
        8'h28: m_ren = wd;
        8'h2C: m_fen = wd;
        default: ;
      endcase
    end
    m_prv = m_s2; m_s2 = m_s1; m_s1 = pins;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [N-1:0] exp);
    reg_addr = a; reg_we = 1'b0;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [N-1:0] pins;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_out", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 irq", {31'b0, irq}, '0);
    rd(8'h0C, "R1 pend", '0);
    rd(8'h28, "R1 rise mask", '0);

    // R2 / R3 set and clear of output levels
    cyc(8'h14, 1, 32'hF0F0_00FF, '0);
    chk("R2 set", pin_out, 32'hF0F0_00FF);
    cyc(8'h14, 1, 32'h0000_0100, '0);
    chk("R2 zero bits kept", pin_out, 32'hF0F0_01FF);
    cyc(8'h18, 1, 32'h00F0_000F, '0);
    chk("R3 clear", pin_out, 32'hF000_01F0);

    // R4 drive enable and readback
    cyc(8'h1C, 1, 32'h8000_0003, '0);
    rd(8'h04, "R4 oe set", 32'h8000_0003);
    cyc(8'h20, 1, 32'h0000_0001, '0);
    chk("R4 oe clear", pin_oe, 32'h8000_0002);

    // R11 writes to read-only/unmapped offsets and reads of write-only offsets
    cyc(8'h00, 1, '1, '0);
    cyc(8'h04, 1, '1, '0);
    cyc(8'h30, 1, '1, '0);
    chk("R11 oe unchanged", pin_oe, 32'h8000_0002);
    chk("R11 out unchanged", pin_out, 32'hF000_01F0);
    rd(8'h14, "R11 set reads zero", '0);
    rd(8'h20, "R11 oe clr reads zero", '0);
    rd(8'h30, "R11 unmapped reads zero", '0);

    // R5 two-flop latency
    cyc(8'h00, 0, '0, 32'h0000_00A5);
    rd(8'h00, "R5 not yet visible", '0);
    cyc(8'h00, 0, '0, 32'h0000_00A5);
    rd(8'h00, "R5 visible after two edges", 32'h0000_00A5);
    cyc(8'h00, 0, '0, 32'h0000_00A5);

    // R12 masks, R6 rising / falling / both, R7 disabled edges
    cyc(8'h28, 1, 32'h0000_0011, 32'h0000_00A5);
    cyc(8'h2C, 1, 32'h0000_0030, 32'h0000_00A5);
    rd(8'h28, "R12 rise mask", 32'h0000_0011);
    rd(8'h2C, "R12 fall mask", 32'h0000_0030);
    // bit4 rises (enabled), bit1 rises (not enabled)
    pins = 32'h0000_00B7;
    cyc(8'h00, 0, '0, pins);
    cyc(8'h00, 0, '0, pins);
    rd(8'h0C, "R6 not before third edge", '0);
    cyc(8'h00, 0, '0, pins);
    rd(8'h0C, "R6 rising latched, R7 bit1 ignored", 32'h0000_0010);
    chk("R10 irq high", {31'b0, irq}, 32'd1);
    // bit5 falls (enabled), bit0 falls (rise only -> ignored)
    pins = 32'h0000_0096;
    repeat (3) cyc(8'h00, 0, '0, pins);
    rd(8'h0C, "R6 falling latched, R7 bit0 ignored", 32'h0000_0030);
    // R8 partial acknowledge
    cyc(8'h0C, 1, 32'h0000_0010, pins);
    rd(8'h0C, "R8 partial clear", 32'h0000_0020);
    cyc(8'h0C, 1, 32'h0000_0020, pins);
    chk("R10 irq low", {31'b0, irq}, '0);

    // R6 both edges on bit 8
    cyc(8'h28, 1, 32'h0000_0100, pins);
    cyc(8'h2C, 1, 32'h0000_0100, pins);
    pins = pins | 32'h100;
    repeat (3) cyc(8'h00, 0, '0, pins);
    rd(8'h0C, "R6 both: rise", 32'h0000_0100);
    cyc(8'h0C, 1, '1, pins);
    pins = pins & ~32'h100;
    repeat (3) cyc(8'h00, 0, '0, pins);
    rd(8'h0C, "R6 both: fall", 32'h0000_0100);

    // R9 acknowledge in the same cycle as a fresh edge
    cyc(8'h0C, 1, '1, pins);
    rd(8'h0C, "R8 all cleared", '0);
    pins = pins | 32'h100;
    cyc(8'h00, 0, '0, pins);
    cyc(8'h00, 0, '0, pins);
    cyc(8'h0C, 1, 32'h0000_0100, pins);
    rd(8'h0C, "R9 edge beats clear", 32'h0000_0100);
    chk("R9 irq stays", {31'b0, irq}, 32'd1);

    // Random run against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [7:0] amap [12];
      amap = '{8'h00, 8'h04, 8'h0C, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h28, 8'h2C,
               8'h08, 8'h30, 8'hFC};
      a = amap[$urandom_range(0, 11)];
      pins = pins ^ ($urandom & $urandom & $urandom);
      cyc(a, $urandom_range(0, 1) == 1, $urandom, pins);
      chk("R2/R3 random pin_out", pin_out, m_out);
      chk("R4 random pin_oe", pin_oe, m_oe);
      chk("R10 random irq", {31'b0, irq}, {31'b0, |m_pend});
      a = amap[$urandom_range(0, 11)];
      rd(a, req_of(a), exp_read(a));
    end

    done = 1;
    summary();
  end
endmodule